// File: doc/BRIEF.md
# Rank-configurable generalized parallel counter

This block adds up a column of single-bit inputs in which every bit carries a weight of either one or two. In plain mode all bits count as one, so the block works as an ordinary m:n counter and reports how many input bits are high. In generalized mode a per-input rank vector gives each bit rank 0 (weight 1) or rank 1 (weight 2). This lets one physical counter stand in for many fixed generalized counter shapes that span two adjacent columns.

The result is a plain binary word. By default the word is wide enough for the largest possible weighted sum, which is all inputs high and all ranked 1. The width can be made smaller: for example 4 bits for 15 inputs matches a classic 15:4 counter. For any width, a configuration check flags a mode and rank setting whose worst-case sum cannot fit. A parameter chooses between a purely combinational output and an output register with a clock enable. The register has an asynchronous active-low reset whose release is synchronised inside the block.

Top module: `gpc_rank_counter`

## Requirements
- R1: With `gen_mode` = 0, the sum equals the number of set bits in `bits_in`, and `rank_cfg` has no effect on either output.
- R2: With `gen_mode` = 1, an input whose `rank_cfg` bit is 1 adds 2 to the sum, and an input whose `rank_cfg` bit is 0 adds 1.
- R3: `cfg_ovf` is 1 exactly when N_IN plus (in generalized mode) the number of ones in `rank_cfg` exceeds 2^SUM_W - 1. `sum_out` always carries the weighted sum modulo 2^SUM_W.
- R4: In plain mode, with SUM_W at least ceil(log2(N_IN+1)) (4 bits for 15 inputs), `cfg_ovf` stays 0.
- R5: With REG_OUT = 1, both outputs take the new result on a rising clock edge where `en` = 1, and hold their value on an edge where `en` = 0.
- R6: With REG_OUT = 1, driving `rst_n` low clears both outputs to 0 at once. They stay 0 through the first two rising edges after `rst_n` returns high, and the third edge loads the first result.
- R7: With REG_OUT = 0, both outputs follow the inputs with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| en | input | 1 | Clock enable for the output register |
| gen_mode | input | 1 | 0: every input has weight 1; 1: weights come from `rank_cfg` |
| bits_in | input | N_IN | Column of input bits to be counted |
| rank_cfg | input | N_IN | Per-input rank: 1 gives weight 2, 0 gives weight 1 |
| sum_out | output | SUM_W | Weighted population count, modulo 2^SUM_W |
| cfg_ovf | output | 1 | Worst-case sum of the current setting does not fit in SUM_W bits |

## Verification
The bench builds two copies with 15 inputs. The first is registered, with the default 5-bit output. Every weighted sum up to 30 is then visible, and the enable hold and the synchronised reset release can be exercised. The second is combinational and has a 4-bit output, the width of a plain 15:4 counter. There any generalized setting with a rank-1 bit raises the overflow flag and large sums wrap, while plain mode must never flag.

// File: rtl/gpc_pkg.sv
package gpc_pkg;

  // Number of bits needed to hold values 0..max_val.
  function automatic int bits_for(input int max_val);
    if (max_val < 1) return 1;
    return $clog2(max_val + 1);
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/gpc_rst_sync.sv
module gpc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic stage1_q, stage2_q;
  logic stage1_d, stage2_d;

  always_comb begin
    stage1_d = 1'b1;
    stage2_d = stage1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= stage1_d;
      stage2_q <= stage2_d;
    end
  end

  assign rst_q_n = stage2_q;

endmodule

// File: rtl/gpc_rank_split.sv
module gpc_rank_split #(
  parameter int N_IN = 15
) (
  input  logic            gen_mode,
  input  logic [N_IN-1:0] bits_in,
  input  logic [N_IN-1:0] rank_cfg,
  output logic [N_IN-1:0] eff_rank,
  output logic [N_IN-1:0] lo_bits,
  output logic [N_IN-1:0] hi_bits
);

  // Plain mode forces every input to rank 0.
  for (genvar i = 0; i < N_IN; i++) begin : g_bit
    assign eff_rank[i] = gen_mode & rank_cfg[i];
    assign hi_bits[i]  = bits_in[i] &  eff_rank[i];
    assign lo_bits[i]  = bits_in[i] & ~eff_rank[i];
  end

endmodule

// File: rtl/gpc_popcount.sv
module gpc_popcount #(
  parameter int W     = 15,
  parameter int OUT_W = gpc_pkg::bits_for(W)
) (
  input  logic [W-1:0]     vec,
  output logic [OUT_W-1:0] cnt
);

  always_comb begin
    cnt = '0;
    for (int i = 0; i < W; i++) begin
      cnt = cnt + OUT_W'(vec[i]);
    end
  end

endmodule

// File: rtl/gpc_rank_counter.sv
module gpc_rank_counter #(
  parameter int N_IN    = 15,
  parameter int SUM_W   = gpc_pkg::bits_for(2 * N_IN),
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             gen_mode,
  input  logic [N_IN-1:0]  bits_in,
  input  logic [N_IN-1:0]  rank_cfg,
  output logic [SUM_W-1:0] sum_out,
  output logic             cfg_ovf
);

  localparam int CNT_W  = gpc_pkg::bits_for(N_IN);
  localparam int FULL_W = gpc_pkg::bits_for(2 * N_IN);
  localparam int LIM_W  = gpc_pkg::max_of(FULL_W, SUM_W) + 1;
  localparam logic [LIM_W-1:0] OUT_MAX = LIM_W'((1 << SUM_W) - 1);

  logic [N_IN-1:0]   eff_rank, lo_bits, hi_bits;
  logic [CNT_W-1:0]  lo_cnt, hi_cnt, rank_cnt;
  logic [FULL_W-1:0] full_sum;
  logic [LIM_W-1:0]  worst_sum;
  logic [SUM_W-1:0]  sum_nxt;
  logic              ovf_nxt;
  logic              rst_q_n;

  gpc_rank_split #(.N_IN(N_IN)) u_split (
    .gen_mode (gen_mode),
    .bits_in  (bits_in),
    .rank_cfg (rank_cfg),
    .eff_rank (eff_rank),
    .lo_bits  (lo_bits),
    .hi_bits  (hi_bits)
  );

  gpc_popcount #(.W(N_IN), .OUT_W(CNT_W)) u_pc_lo (
    .vec (lo_bits),
    .cnt (lo_cnt)
  );

  gpc_popcount #(.W(N_IN), .OUT_W(CNT_W)) u_pc_hi (
    .vec (hi_bits),
    .cnt (hi_cnt)
  );

  gpc_popcount #(.W(N_IN), .OUT_W(CNT_W)) u_pc_rank (
    .vec (eff_rank),
    .cnt (rank_cnt)
  );

  // Rank-1 column is shifted one place before the final add.
  always_comb begin
    full_sum  = FULL_W'(lo_cnt) + FULL_W'({hi_cnt, 1'b0});
    sum_nxt   = SUM_W'(full_sum);
    worst_sum = LIM_W'(N_IN) + LIM_W'(rank_cnt);
    ovf_nxt   = (worst_sum > OUT_MAX);
  end

  if (REG_OUT) begin : g_reg
    logic [SUM_W-1:0] sum_d, sum_q;
    logic             ovf_d, ovf_q;

    gpc_rst_sync u_rst_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .rst_q_n (rst_q_n)
    );

    always_comb begin
      sum_d = sum_q;
      ovf_d = ovf_q;
      if (en) begin
        sum_d = sum_nxt;
        ovf_d = ovf_nxt;
      end
    end

    always_ff @(posedge clk or negedge rst_q_n) begin
      if (!rst_q_n) begin
        sum_q <= '0;
        ovf_q <= 1'b0;
      end else begin
        sum_q <= sum_d;
        ovf_q <= ovf_d;
      end
    end

    assign sum_out = sum_q;
    assign cfg_ovf = ovf_q;
  end else begin : g_comb
    assign rst_q_n = rst_n;
    assign sum_out = sum_nxt;
    assign cfg_ovf = ovf_nxt;
  end

endmodule

// File: rtl/gpc_rank_counter_chk.sv
module gpc_rank_counter_chk #(
  parameter int N_IN    = 15,
  parameter int SUM_W   = 5,
  parameter bit REG_OUT = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_int_n,
  input logic             en,
  input logic             gen_mode,
  input logic [N_IN-1:0]  bits_in,
  input logic [N_IN-1:0]  rank_cfg,
  input logic [SUM_W-1:0] sum_out,
  input logic             cfg_ovf
);

  localparam int CNT_W = gpc_pkg::bits_for(N_IN);
  localparam int MODV  = 1 << SUM_W;

  if (REG_OUT) begin : g_reg_chk
    a_r1_plain_count: assert property (@(posedge clk) disable iff (!rst_int_n)
      ($past(rst_int_n) && $past(en) && !$past(gen_mode)) |->
        (int'(sum_out) == ($past($countones(bits_in)) % MODV)));

    a_r2_gen_bounds: assert property (@(posedge clk) disable iff (!rst_int_n)
      ($past(rst_int_n) && $past(en) && $past(gen_mode) && !cfg_ovf) |->
        ((int'(sum_out) >= $past($countones(bits_in))) &&
         (int'(sum_out) <= 2 * $past($countones(bits_in)))));

    if (SUM_W >= CNT_W) begin : g_plain_fit
      a_r4_plain_no_ovf: assert property (@(posedge clk) disable iff (!rst_int_n)
        ($past(rst_int_n) && $past(en) && !$past(gen_mode)) |-> !cfg_ovf);
    end

    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_int_n)
      ($past(rst_int_n) && !$past(en)) |-> ($stable(sum_out) && $stable(cfg_ovf)));
  end else begin : g_comb_chk
    a_r7_plain_count: assert property (@(posedge clk) disable iff (!rst_n)
      !gen_mode |-> (int'(sum_out) == ($countones(bits_in) % MODV)));

    a_r2_gen_bounds: assert property (@(posedge clk) disable iff (!rst_n)
      (gen_mode && !cfg_ovf) |->
        ((int'(sum_out) >= $countones(bits_in)) &&
         (int'(sum_out) <= 2 * $countones(bits_in))));

    a_r3_zero_rank_fit: assert property (@(posedge clk) disable iff (!rst_n)
      (gen_mode && (rank_cfg == '0) && (SUM_W >= CNT_W)) |-> !cfg_ovf);
  end

endmodule

bind gpc_rank_counter gpc_rank_counter_chk #(
  .N_IN    (N_IN),
  .SUM_W   (SUM_W),
  .REG_OUT (REG_OUT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rst_int_n (rst_q_n),
  .en        (en),
  .gen_mode  (gen_mode),
  .bits_in   (bits_in),
  .rank_cfg  (rank_cfg),
  .sum_out   (sum_out),
  .cfg_ovf   (cfg_ovf)
);

// File: tb/gpc_rank_counter_test.sv
module gpc_rank_counter_test;

  localparam int N  = 15;
  localparam int WW = 5;
  localparam int NW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          en;
  logic          gen_mode;
  logic [N-1:0]  bits_in;
  logic [N-1:0]  rank_cfg;
  logic [WW-1:0] w_sum;
  logic          w_ovf;
  logic [NW-1:0] n_sum;
  logic          n_ovf;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;
  int w_exp_sum = 0;
  int w_exp_ovf = 0;

  always #5 clk = ~clk;

  gpc_rank_counter #(.N_IN(N), .SUM_W(WW), .REG_OUT(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .gen_mode(gen_mode),
    .bits_in(bits_in), .rank_cfg(rank_cfg), .sum_out(w_sum), .cfg_ovf(w_ovf)
  );

  gpc_rank_counter #(.N_IN(N), .SUM_W(NW), .REG_OUT(1'b0)) uut_narrow (
    .clk(clk), .rst_n(rst_n), .en(en), .gen_mode(gen_mode),
    .bits_in(bits_in), .rank_cfg(rank_cfg), .sum_out(n_sum), .cfg_ovf(n_ovf)
  );

  function automatic int ref_sum(input logic [N-1:0] b, input logic [N-1:0] c,
                                 input logic m);
    int s = 0;
    for (int i = 0; i < N; i++) begin
      if (b[i]) s += (m && c[i]) ? 2 : 1;
    end
    return s;
  endfunction

  function automatic int ref_ovf(input logic [N-1:0] c, input logic m, input int w);
    int worst = N;
    if (m) begin
      for (int i = 0; i < N; i++) worst += int'(c[i]);
    end
    return (worst > (1 << w) - 1) ? 1 : 0;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Called at a negedge: drive, check combinational copy, then registered copy.
  task automatic apply(input logic [N-1:0] b, input logic [N-1:0] c,
                       input logic m, input logic e, input string tag);
    int s;
    bits_in  = b;
    rank_cfg = c;
    gen_mode = m;
    en       = e;
    s = ref_sum(b, c, m);
    #1;
    chk({"R7 ", tag, " narrow sum"}, int'(n_sum), s % (1 << NW));
    chk({"R7 ", tag, " narrow ovf"}, int'(n_ovf), ref_ovf(c, m, NW));
    if (e) begin
      w_exp_sum = s % (1 << WW);
      w_exp_ovf = ref_ovf(c, m, WW);
    end
    @(negedge clk);
    chk({tag, " wide sum"}, int'(w_sum), w_exp_sum);
    chk({tag, " wide ovf"}, int'(w_ovf), w_exp_ovf);
  endtask

  initial begin
    #2ms;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd48611));
    rst_n = 1'b0; en = 1'b0; gen_mode = 1'b0; bits_in = '0; rank_cfg = '0;
    repeat (3) @(negedge clk);
    chk("R6 reset sum", int'(w_sum), 0);
    chk("R6 reset ovf", int'(w_ovf), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Directed corners
    apply('0, '0, 1'b0, 1'b1, "R1 all zero");
    apply('1, '1, 1'b0, 1'b1, "R1 R4 plain all ones, ranks ignored");
    apply(15'h5555, 15'h7FFF, 1'b0, 1'b1, "R1 plain alternating");
    apply('1, '1, 1'b1, 1'b1, "R2 R3 gen all rank1");
    apply('1, 15'h00FF, 1'b1, 1'b1, "R2 gen mixed ranks");
    apply(15'h0003, 15'h0001, 1'b1, 1'b1, "R2 gen one of each");
    apply('0, 15'h0100, 1'b1, 1'b1, "R3 single rank1 flags narrow");
    apply('1, '0, 1'b1, 1'b1, "R3 gen rank0 fits");

    // R5 hold: load a value, then change inputs with en low
    apply(15'h00F0, 15'h0030, 1'b1, 1'b1, "R5 load");
    apply('1, '1, 1'b1, 1'b0, "R5 hold en low");
    apply(15'h1234, '1, 1'b0, 1'b0, "R5 hold again");
    apply(15'h1234, '1, 1'b0, 1'b1, "R5 reload");

    // R6 async clear and synchronised release
    apply('1, '0, 1'b0, 1'b1, "R6 preload");
    rst_n = 1'b0;
    #1;
    chk("R6 async clear sum", int'(w_sum), 0);
    chk("R6 async clear ovf", int'(w_ovf), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R6 zero after edge 1", int'(w_sum), 0);
    @(negedge clk);
    chk("R6 zero after edge 2", int'(w_sum), 0);
    @(negedge clk);
    chk("R6 load at edge 3", int'(w_sum), 15);
    w_exp_sum = 15;
    w_exp_ovf = 0;

    // Random mix
    for (int k = 0; k < 400; k++) begin
      logic [N-1:0] rb, rc;
      logic rm, re;
      rb = N'($urandom);
      rc = N'($urandom);
      rm = 1'($urandom);
      re = (($urandom % 8) != 0);
      apply(rb, rc, rm, re, rm ? "R2 R3 R5 random gen" : "R1 R4 R5 random plain");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule